// File: doc/BRIEF.md
# Debug event capture and interrupt controller

This block sits next to a processor pipeline and turns debug events into debug interrupt requests. Each cycle it receives one pulse per data-address-compare event: two comparators, each with a read and a write flavour. It also receives a pulse when a trap instruction's condition is met. Every recognised event is latched in a sticky status bit that only software can clear, with write-one-to-clear strobes.

When debug interrupts are enabled, an event requests a debug interrupt on the next clock edge, and the saved return address is loaded with the address of the excepting instruction. A compare event also suppresses its instruction. When debug interrupts are disabled, no debug interrupt is raised. The event is left pending in the status register and an imprecise flag is set. A trap event in this case requests a trap-type program interrupt instead. When the enable later rises while any status bit is still set, a single delayed debug interrupt fires. Its saved address is the address of the instruction after the one that set the enable.

Top module: `dbg_event_ctrl`

## Requirements
- R1: Status bit 2k latches a read event of comparator k and bit 2k+1 latches a write event of comparator k (k = 0, 1). Bit 4 latches a trap event. A set bit stays set until it is cleared.
- R2: A compare event while `dbg_en`=1 and `hp_exc`=0 makes `dbg_irq` and `suppress` high for one cycle after the next clock edge, and loads `save_pc` with `cur_pc`.
- R3: An event of any kind while `dbg_en`=0 raises neither `dbg_irq` nor `suppress`, and it sets `imprecise`.
- R4: A trap event is recognised only when `trap_hit` and `trap_en` are both 1, whatever the value of `dbg_en`. With `dbg_en`=1 and `hp_exc`=0 it pulses `dbg_irq` and loads `save_pc` with `cur_pc`, without `suppress`.
- R5: A trap event while `dbg_en`=0 pulses `trap_prog_irq` for one cycle after the next clock edge, whatever `hp_exc` is.
- R6: In a cycle where `dbg_en` is 1, having been 0 in the previous cycle, a status bit that is set and not cleared in that same cycle pulses `dbg_irq` and loads `save_pc` with `next_pc`.
- R7: A 1 on `clr_stat[i]` clears status bit i. Clearing every pending bit before the enable rises cancels the delayed interrupt.
- R8: With `hp_exc`=1, neither an immediate nor a delayed interrupt is raised and `save_pc` keeps its value. The status bits are still captured.
- R9: A set and a clear of the same status bit in one cycle leave the bit at 1. The same rule applies to `imprecise` and `clr_imp`.
- R10: An active-low synchronous reset clears the status, `imprecise`, `save_pc` and all request outputs.
- R11: While `dbg_en` stays 1 and no new event arrives, no further `dbg_irq` is raised, even if status bits remain set.
- R12: When an immediate and a delayed interrupt coincide, one `dbg_irq` pulse is raised and `save_pc` takes `cur_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_rd_hit | input | 2 | Read compare event pulse per comparator |
| cmp_wr_hit | input | 2 | Write compare event pulse per comparator |
| trap_hit | input | 1 | Trap instruction condition met |
| trap_en | input | 1 | Trap event detection enable |
| dbg_en | input | 1 | Debug interrupt enable |
| hp_exc | input | 1 | Higher-priority exception taken this cycle |
| cur_pc | input | 32 | Address of the excepting instruction |
| next_pc | input | 32 | Address of the following instruction |
| clr_stat | input | 5 | Write-one-to-clear strobes for status bits |
| clr_imp | input | 1 | Write-one-to-clear strobe for the imprecise flag |
| stat | output | 5 | Sticky event status |
| imprecise | output | 1 | Event seen while debug interrupts were disabled |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| suppress | output | 1 | Suppress the causing instruction |
| trap_prog_irq | output | 1 | Trap-type program interrupt request pulse |
| save_pc | output | 32 | Saved return address |

## Verification
On every cycle, the assertions check the status bit rules: each bit holds, a set wins over a clear, and a clear acts when there is no set. They also check that an immediate request loads the faulting address, that a higher-priority exception blocks requests, that the trap-type program interrupt follows a disabled trap, that the imprecise flag is set, and that no repeat interrupt occurs while the enable is held. Some behaviours depend on a history of several cycles, and only the bench scenarios show them. These are the deferred interrupt with its next-instruction address, the cancelling of a pending interrupt by a clear, the priority of an immediate interrupt over a coincident delayed one, and an event blocked by a higher-priority exception that fires later.

// File: rtl/dbg_event_pkg.sv
// Shared types and constants for the debug event controller.
// Assumes a status layout of interleaved read/write bits per comparator
// followed by a single trap bit.
package dbg_event_pkg;

    // Source of a debug interrupt request in a given cycle.
    typedef enum logic [1:0] {
        IRQ_NONE    = 2'd0,
        IRQ_IMM     = 2'd1,
        IRQ_DELAYED = 2'd2
    } dbg_irq_kind_e;

    // Status bit index of a comparator event (write selects the odd bit).
    function automatic int unsigned cmp_bit(input int unsigned cmp, input bit wr);
        return 2 * cmp + (wr ? 1 : 0);
    endfunction

endpackage

// File: rtl/dbg_event_decode.sv
// Event decoder: folds the per-comparator compare pulses and the gated
// trap pulse into one status-set vector and two summary flags.
// Assumes the inputs are single-cycle pulses, already qualified by the pipeline.
module dbg_event_decode
    import dbg_event_pkg::*;
#(
    parameter int NUM_CMP = 2,
    localparam int NSTAT  = 2 * NUM_CMP + 1
) (
    input  logic [NUM_CMP-1:0] cmp_rd_hit,
    input  logic [NUM_CMP-1:0] cmp_wr_hit,
    input  logic               trap_hit,
    input  logic               trap_en,
    output logic [NSTAT-1:0]   evt_vec,
    output logic               cmp_any,
    output logic               trap_evt
);

    genvar k;
    generate
        for (k = 0; k < NUM_CMP; k++) begin : g_cmp
            // Place the read and write pulses of comparator k in their bits.
            always_comb begin
                evt_vec[cmp_bit(k, 1'b0)] = cmp_rd_hit[k];
                evt_vec[cmp_bit(k, 1'b1)] = cmp_wr_hit[k];
            end
        end
    endgenerate

    // Trap event is recognised only when detection is enabled.
    always_comb begin
        trap_evt           = trap_hit && trap_en;
        evt_vec[NSTAT-1]   = trap_evt;
        cmp_any            = |{cmp_rd_hit, cmp_wr_hit};
    end

endmodule

// File: rtl/dbg_status_reg.sv
// Sticky status register with write-one-to-clear bits and an imprecise flag.
// A set arriving in the same cycle as a clear wins. pend reports whether
// any bit survives this cycle's clear strobes (it ignores new sets).
module dbg_status_reg #(
    parameter int NSTAT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSTAT-1:0] set_vec,
    input  logic [NSTAT-1:0] clr_vec,
    input  logic             set_imp,
    input  logic             clr_imp,
    output logic [NSTAT-1:0] stat_q,
    output logic             imp_q,
    output logic             pend
);

    genvar i;
    generate
        for (i = 0; i < NSTAT; i++) begin : g_bit
            // One sticky bit: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[i] <= 1'b0;
                else if (set_vec[i])
                    stat_q[i] <= 1'b1;
                else if (clr_vec[i])
                    stat_q[i] <= 1'b0;
            end

            // R1
            sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                stat_q[i] && !clr_vec[i] |=> stat_q[i]);
            // R9
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> stat_q[i]);
            // R7
            clear_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr_vec[i] && !set_vec[i] |=> !stat_q[i]);
        end
    endgenerate

    // Imprecise flag with the same set-over-clear rule.
    always_ff @(posedge clk) begin
        if (!rst_n)
            imp_q <= 1'b0;
        else if (set_imp)
            imp_q <= 1'b1;
        else if (clr_imp)
            imp_q <= 1'b0;
    end

    // Pending status after this cycle's software clears.
    always_comb pend = |(stat_q & ~clr_vec);

endmodule

// File: rtl/dbg_irq_gen.sv
// Request generator: decides between immediate and delayed debug
// interrupts, raises the suppress and trap-type program requests, and
// holds the saved return address. All outputs are registered pulses.
// Assumes dbg_en is a level taken from the machine state each cycle.
module dbg_irq_gen
    import dbg_event_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic              hp_exc,
    input  logic              cmp_any,
    input  logic              trap_evt,
    input  logic              pend,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] next_pc,
    output logic              dbg_irq,
    output logic              suppress,
    output logic              trap_prog_irq,
    output logic [ADDR_W-1:0] save_pc
);

    logic          en_q;
    logic          en_rise;
    dbg_irq_kind_e kind;

    // Classify this cycle's request; immediate outranks delayed.
    always_comb begin
        en_rise = dbg_en && !en_q;
        kind    = IRQ_NONE;
        if (!hp_exc) begin
            if ((cmp_any || trap_evt) && dbg_en)
                kind = IRQ_IMM;
            else if (en_rise && pend)
                kind = IRQ_DELAYED;
        end
    end

    // Register the request pulses and the enable history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q          <= 1'b0;
            dbg_irq       <= 1'b0;
            suppress      <= 1'b0;
            trap_prog_irq <= 1'b0;
        end else begin
            en_q          <= dbg_en;
            dbg_irq       <= (kind != IRQ_NONE);
            suppress      <= (kind == IRQ_IMM) && cmp_any;
            trap_prog_irq <= trap_evt && !dbg_en;
        end
    end

    // Capture the return address matching the request kind.
    always_ff @(posedge clk) begin
        if (!rst_n)
            save_pc <= '0;
        else if (kind == IRQ_IMM)
            save_pc <= cur_pc;
        else if (kind == IRQ_DELAYED)
            save_pc <= next_pc;
    end

    // R2
    imm_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_any || trap_evt) && dbg_en && !hp_exc |=> dbg_irq && (save_pc == $past(cur_pc)));
    // R8
    hp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_exc |=> !dbg_irq && !suppress && $stable(save_pc));
    // R11
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && dbg_en && !cmp_any && !trap_evt |=> !dbg_irq);
    // R5
    prog_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_evt && !dbg_en |=> trap_prog_irq && !dbg_irq);
    // R2
    suppress_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> dbg_irq);

endmodule

// File: rtl/dbg_event_ctrl.sv
// Top of the debug event controller: decodes events, keeps sticky status
// and the imprecise flag, and issues immediate or delayed debug interrupts.
// Assumes all inputs are synchronous to clk and event inputs are pulses.
module dbg_event_ctrl #(
    parameter int NUM_CMP = 2,
    parameter int ADDR_W  = 32,
    localparam int NSTAT  = 2 * NUM_CMP + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_rd_hit,
    input  logic [NUM_CMP-1:0] cmp_wr_hit,
    input  logic               trap_hit,
    input  logic               trap_en,
    input  logic               dbg_en,
    input  logic               hp_exc,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic [ADDR_W-1:0]  next_pc,
    input  logic [NSTAT-1:0]   clr_stat,
    input  logic               clr_imp,
    output logic [NSTAT-1:0]   stat,
    output logic               imprecise,
    output logic               dbg_irq,
    output logic               suppress,
    output logic               trap_prog_irq,
    output logic [ADDR_W-1:0]  save_pc
);

    logic [NSTAT-1:0] evt_vec;
    logic             cmp_any;
    logic             trap_evt;
    logic             pend;
    logic             set_imp;

    dbg_event_decode #(.NUM_CMP(NUM_CMP)) u_decode (
        .cmp_rd_hit (cmp_rd_hit),
        .cmp_wr_hit (cmp_wr_hit),
        .trap_hit   (trap_hit),
        .trap_en    (trap_en),
        .evt_vec    (evt_vec),
        .cmp_any    (cmp_any),
        .trap_evt   (trap_evt)
    );

    // An event seen while debug interrupts are off is imprecise.
    always_comb set_imp = (cmp_any || trap_evt) && !dbg_en;

    dbg_status_reg #(.NSTAT(NSTAT)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_vec),
        .clr_vec (clr_stat),
        .set_imp (set_imp),
        .clr_imp (clr_imp),
        .stat_q  (stat),
        .imp_q   (imprecise),
        .pend    (pend)
    );

    dbg_irq_gen #(.ADDR_W(ADDR_W)) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .dbg_en        (dbg_en),
        .hp_exc        (hp_exc),
        .cmp_any       (cmp_any),
        .trap_evt      (trap_evt),
        .pend          (pend),
        .cur_pc        (cur_pc),
        .next_pc       (next_pc),
        .dbg_irq       (dbg_irq),
        .suppress      (suppress),
        .trap_prog_irq (trap_prog_irq),
        .save_pc       (save_pc)
    );

    // R3
    imp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{cmp_rd_hit, cmp_wr_hit} || (trap_hit && trap_en)) && !dbg_en |=> imprecise && !suppress);
    // R3
    no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |=> !dbg_irq);

endmodule

// File: tb/dbg_event_ctrl_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios for each requirement and a random stretch.
module dbg_event_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmp_rd_hit = '0;
    logic [1:0]  cmp_wr_hit = '0;
    logic        trap_hit = 1'b0;
    logic        trap_en = 1'b0;
    logic        dbg_en = 1'b0;
    logic        hp_exc = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] next_pc = '0;
    logic [4:0]  clr_stat = '0;
    logic        clr_imp = 1'b0;
    logic [4:0]  stat;
    logic        imprecise, dbg_irq, suppress, trap_prog_irq;
    logic [31:0] save_pc;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    dbg_event_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_rd_hit(cmp_rd_hit), .cmp_wr_hit(cmp_wr_hit),
        .trap_hit(trap_hit), .trap_en(trap_en), .dbg_en(dbg_en), .hp_exc(hp_exc),
        .cur_pc(cur_pc), .next_pc(next_pc), .clr_stat(clr_stat), .clr_imp(clr_imp),
        .stat(stat), .imprecise(imprecise), .dbg_irq(dbg_irq), .suppress(suppress),
        .trap_prog_irq(trap_prog_irq), .save_pc(save_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    bit [4:0]  m_stat;
    bit        m_imp, m_irq, m_sup, m_prog, m_prev;
    bit [31:0] m_pc;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Reference model: behaviour from the requirements, per clock edge.
    always @(posedge clk) begin
        bit [4:0] ev;
        bit any, cany, imm, del, pend, rise;
        started = 1;
        if (!rst_n) begin
            m_stat = 0; m_imp = 0; m_irq = 0; m_sup = 0; m_prog = 0; m_prev = 0; m_pc = 0;
        end else begin
            ev = {trap_hit && trap_en, cmp_wr_hit[1], cmp_rd_hit[1], cmp_wr_hit[0], cmp_rd_hit[0]};
            any  = (ev != 0);
            cany = (ev[3:0] != 0);
            rise = dbg_en && !m_prev;
            pend = ((m_stat & ~clr_stat) != 0);
            imm  = any && dbg_en && !hp_exc;
            del  = !imm && rise && pend && !hp_exc;
            m_irq  = imm || del;
            m_sup  = imm && cany;
            m_prog = ev[4] && !dbg_en;
            if (imm) m_pc = cur_pc;
            else if (del) m_pc = next_pc;
            m_stat = (m_stat & ~clr_stat) | ev;
            m_imp  = (m_imp && !clr_imp) || (any && !dbg_en);
            m_prev = dbg_en;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 stat vs model", stat, m_stat);
            chk("R3 imprecise vs model", imprecise, m_imp);
            chk("R6 dbg_irq vs model", dbg_irq, m_irq);
            chk("R2 suppress vs model", suppress, m_sup);
            chk("R5 trap_prog_irq vs model", trap_prog_irq, m_prog);
            chk("R12 save_pc vs model", save_pc, m_pc);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_rd_hit = '0; cmp_wr_hit = '0; trap_hit = 0; hp_exc = 0;
        clr_stat = '0; clr_imp = 0;
    endtask

    task automatic clear_all();
        clr_stat = 5'h1f; clr_imp = 1; tick();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired act=1 exp=0");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        // R10 reset state
        chk("R10 stat", stat, 0); chk("R10 imprecise", imprecise, 0);
        chk("R10 dbg_irq", dbg_irq, 0); chk("R10 prog", trap_prog_irq, 0);
        chk("R10 save_pc", save_pc, 0);
        rst_n = 1; trap_en = 1; dbg_en = 1; tick();

        // R2 immediate compare interrupt
        cmp_rd_hit[0] = 1; cur_pc = 32'h100; tick();
        chk("R2 dbg_irq", dbg_irq, 1); chk("R2 suppress", suppress, 1);
        chk("R2 save_pc", save_pc, 32'h100); chk("R1 bit0", stat, 5'b00001);
        tick();
        chk("R2 pulse ends", dbg_irq, 0);
        clr_stat = 5'h1f; tick();
        chk("R7 cleared", stat, 0);

        // R1 bit mapping, comparator 1 write
        cmp_wr_hit[1] = 1; cur_pc = 32'h104; tick();
        chk("R1 bit3", stat, 5'b01000);
        clear_all();

        // R3 disabled event
        dbg_en = 0; cmp_wr_hit[0] = 1; cur_pc = 32'h200; tick();
        chk("R3 no irq", dbg_irq, 0); chk("R3 no suppress", suppress, 0);
        chk("R3 imprecise", imprecise, 1); chk("R1 bit1", stat, 5'b00010);

        // R6 delayed interrupt on enable rise
        dbg_en = 1; next_pc = 32'h300; tick();
        chk("R6 dbg_irq", dbg_irq, 1); chk("R6 save_pc", save_pc, 32'h300);
        chk("R6 no suppress", suppress, 0);

        // R11 no repeat while held
        for (int n = 0; n < 3; n++) begin
            tick();
            chk("R11 no repeat", dbg_irq, 0);
        end
        clear_all();
        chk("R7 imprecise cleared", imprecise, 0);

        // R7 clear cancels the pending delayed interrupt
        dbg_en = 0; cmp_rd_hit[1] = 1; tick();
        clr_stat = 5'b00100; tick();
        dbg_en = 1; next_pc = 32'h400; tick();
        chk("R7 cancelled irq", dbg_irq, 0); chk("R7 save_pc kept", save_pc, 32'h300);
        clear_all();

        // R5 trap while disabled
        dbg_en = 0; trap_hit = 1; cur_pc = 32'h500; tick();
        chk("R5 prog irq", trap_prog_irq, 1); chk("R5 no dbg_irq", dbg_irq, 0);
        chk("R4 trap bit", stat, 5'b10000); chk("R5 imprecise", imprecise, 1);
        clear_all();
        // R4 trap ignored when detection disabled
        trap_en = 0; trap_hit = 1; tick();
        chk("R4 ignored stat", stat, 0); chk("R4 ignored prog", trap_prog_irq, 0);
        chk("R4 ignored imprecise", imprecise, 0);
        // R4 trap while enabled
        trap_en = 1; dbg_en = 1; tick();
        trap_hit = 1; cur_pc = 32'h600; tick();
        chk("R4 dbg_irq", dbg_irq, 1); chk("R4 no suppress", suppress, 0);
        chk("R4 save_pc", save_pc, 32'h600);
        clear_all();

        // R8 higher-priority exception blocks, status still captured
        hp_exc = 1; cmp_rd_hit[0] = 1; cur_pc = 32'h700; tick();
        chk("R8 blocked", dbg_irq, 0); chk("R8 captured", stat, 5'b00001);
        chk("R8 save_pc kept", save_pc, 32'h600);
        dbg_en = 0; tick();
        dbg_en = 1; next_pc = 32'h800; tick();
        chk("R8 later delayed", dbg_irq, 1); chk("R8 delayed pc", save_pc, 32'h800);

        // R9 set wins over clear
        dbg_en = 0; cmp_rd_hit[0] = 1; clr_stat = 5'b00001; clr_imp = 1; tick();
        chk("R9 stat set wins", stat[0], 1); chk("R9 imprecise set wins", imprecise, 1);

        // R12 immediate outranks coincident delayed
        dbg_en = 1; cmp_wr_hit[1] = 1; cur_pc = 32'h900; next_pc = 32'h904; tick();
        chk("R12 irq", dbg_irq, 1); chk("R12 save_pc", save_pc, 32'h900);
        chk("R12 suppress", suppress, 1);
        clear_all();

        // Random stretch checked by the model every cycle.
        for (int n = 0; n < 3000; n++) begin
            cmp_rd_hit = {($urandom % 8) == 0, ($urandom % 8) == 0};
            cmp_wr_hit = {($urandom % 8) == 0, ($urandom % 8) == 0};
            trap_hit   = ($urandom % 8) == 0;
            trap_en    = ($urandom % 6) != 0;
            hp_exc     = ($urandom % 8) == 0;
            if (($urandom % 10) == 0) dbg_en = ~dbg_en;
            cur_pc     = $urandom;
            next_pc    = $urandom;
            clr_stat   = ($urandom % 6) == 0 ? 5'($urandom) : 5'b0;
            clr_imp    = ($urandom % 12) == 0;
            @(posedge clk);
            @(negedge clk);
        end
        tick();

        done = 1;
        summary();
        $finish;
    end

endmodule